// File: doc/BRIEF.md
# Split-Window Performance Counter Bank

The block holds the unprivileged 64-bit counters of a processor with a 32-bit data path. Each counter is twice the machine word wide. Software reads it one word at a time through a 12-bit CSR address port. There are 32 counter slots with fixed roles:
- Slot 0 counts core clocks, but only while the core is clocked.
- Slot 1 counts ticks of an external constant-rate time source.
- Slot 2 adds up the instructions retired in each cycle.
- Slots 3 and up are event counters, one per event strobe, and there are as many as the parameter `NUM_EVT` asks for.
- The slots beyond those are not built and read as zero.

The low words of all slots sit in one 32-entry address window, and the high words sit in a second window. A read presents an address. One clock later, the block returns the chosen word on a registered output, with a flag raised when the address falls outside both windows. Every counter is a single wide register, so the carry out of the low word reaches the high word within the same update. Software that reads the high word, then the low word, then the high word again, and retries when the two high reads differ, always gets a consistent value. Reads never disturb a counter.

Top module: `perf_ctr_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rd_data` is zero and `rd_illegal` is low; every counter starts at zero.
- R2: For an address presented on `rd_addr` in one cycle, `rd_data` after the next rising edge holds the value the counter had in the cycle the address was presented. Addresses 0xC00+s return bits XLEN-1..0 of slot s, and addresses 0xC80+s return bits 2*XLEN-1..XLEN, for s from 0 to 31.
- R3: The slot-0 counter rises by one on every clock edge where `core_run` is 1 and holds when `core_run` is 0.
- R4: The slot-1 counter rises by one on every edge where `rt_tick` is 1, whatever `core_run` is.
- R5: The slot-2 counter adds `ret_cnt` on each edge for the values 0, 1 and 2; the value 3 is treated as 2.
- R6: The counter in slot 3+j rises by one on each edge where `evt_pulse[j]` is 1, for j from 0 to NUM_EVT-1.
- R7: Slots from 3+NUM_EVT to 31 read as zero in both windows and are legal addresses.
- R8: A carry out of the low word of any counter increments its high word on the same edge.
- R9: Any address outside 0xC00–0xC1F and 0xC80–0xC9F sets `rd_illegal` to 1 with `rd_data` zero for that read.
- R10: Reading any address leaves every counter unchanged; with no strobes active, repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_run | input | 1 | 1 while the core is clocked; 0 while it is gated or asleep |
| rt_tick | input | 1 | One-cycle strobe from the constant-rate time source |
| ret_cnt | input | 2 | Instructions retired this cycle (0 to 2; 3 treated as 2) |
| evt_pulse | input | NUM_EVT | One strobe per event counter |
| rd_addr | input | 12 | CSR read address |
| rd_data | output | XLEN | Registered read word |
| rd_illegal | output | 1 | Registered flag: the address was outside both windows |

## Verification
The bench runs several read patterns:
- **Full sweep after reset.** Both windows are read across all 32 slots while nothing counts. This separates a wrong decode, or live data in unbuilt slots, from a correct all-zero result.
- **One strobe per counter.** Each counter is then driven by its own strobe pattern while it is being read: core-run toggles, ticks every third cycle, retire counts cycling 0 to 3, and event bit patterns. A counter tied to the wrong strobe, or a count of 3 not clipped, shows as a drift from the model.
- **Out-of-window addresses.** Addresses just past each window edge must raise the flag and return zero.
- **Idle repeated reads.** Repeated reads with no strobes must return a frozen value.
- **Long carry run.** The bench uses a narrow word so that the cycle counter crosses its low-word boundary. Alternating high and low reads across that boundary expose a lost or late carry.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  localparam int SLOT_N     = 32;
  localparam int SLOT_W     = $clog2(SLOT_N);
  localparam int CSR_AW     = 12;
  localparam int PAGE_W     = CSR_AW - SLOT_W;
  localparam int FIX_N      = 3;
  localparam int SLOT_CYC   = 0;
  localparam int SLOT_TIME  = 1;
  localparam int SLOT_RET   = 2;
  localparam int INC_W      = 2;
  localparam int RET_MAX    = 2;

  localparam logic [CSR_AW-1:0] LO_BASE = 12'hC00;
  localparam logic [CSR_AW-1:0] HI_BASE = 12'hC80;
  localparam logic [PAGE_W-1:0] LO_PAGE = LO_BASE[CSR_AW-1:SLOT_W];
  localparam logic [PAGE_W-1:0] HI_PAGE = HI_BASE[CSR_AW-1:SLOT_W];

  typedef struct packed {
    logic              legal;
    logic              hi;
    logic [SLOT_W-1:0] slot;
  } csr_sel_t;

endpackage

// File: rtl/perf_ctr_decode.sv
module perf_ctr_decode
  import perf_ctr_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  output csr_sel_t          sel
);

  logic [PAGE_W-1:0] page;

  always_comb begin
    page      = addr[CSR_AW-1:SLOT_W];
    sel.slot  = addr[SLOT_W-1:0];
    sel.hi    = (page == HI_PAGE);
    sel.legal = (page == LO_PAGE) || (page == HI_PAGE);
  end

endmodule

// File: rtl/perf_ctr_cell.sv
module perf_ctr_cell #(
  parameter int W     = 64,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);

  localparam int HALF = W / 2;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + W'(inc);
  end

  // R10: a zero increment leaves the count untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (inc == '0) |=> $stable(cnt));

  // R8: low word wrapping carries into the high word on the same edge
  p_carry_r8: assert property (@(posedge clk) disable iff (rst)
    ((cnt[HALF-1:0] == {HALF{1'b1}}) && (inc != '0))
      |=> (cnt[W-1:HALF] == $past(cnt[W-1:HALF]) + HALF'(1)));

  // R8: without a wrap the high word holds
  p_no_spurious_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt[HALF-1:0] < {HALF{1'b1}} - HALF'(INC_W'(-1))) |=> $stable(cnt[W-1:HALF]));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               core_run,
  input  logic               rt_tick,
  input  logic [1:0]         ret_cnt,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [CSR_AW-1:0]  rd_addr,
  output logic [XLEN-1:0]    rd_data,
  output logic               rd_illegal
);

  localparam int CTR_W  = 2 * XLEN;
  localparam int IMPL_N = FIX_N + NUM_EVT;

  logic [CTR_W-1:0] cnt_q [SLOT_N];
  logic [INC_W-1:0] ret_inc;
  csr_sel_t         sel;

  // retire count clipped to the architectural maximum per cycle (R5)
  always_comb begin
    if (ret_cnt > INC_W'(RET_MAX)) ret_inc = INC_W'(RET_MAX);
    else                           ret_inc = ret_cnt;
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    if (s < IMPL_N) begin : g_impl
      logic [INC_W-1:0] inc;
      if (s == SLOT_CYC) begin : g_cyc
        assign inc = {{(INC_W-1){1'b0}}, core_run};
      end else if (s == SLOT_TIME) begin : g_time
        assign inc = {{(INC_W-1){1'b0}}, rt_tick};
      end else if (s == SLOT_RET) begin : g_ret
        assign inc = ret_inc;
      end else begin : g_evt
        assign inc = {{(INC_W-1){1'b0}}, evt_pulse[s-FIX_N]};
      end
      perf_ctr_cell #(.W(CTR_W), .INC_W(INC_W)) u_cell (
        .clk (clk),
        .rst (rst),
        .inc (inc),
        .cnt (cnt_q[s])
      );
    end else begin : g_absent
      assign cnt_q[s] = '0;
    end
  end

  perf_ctr_decode u_dec (
    .addr (rd_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_illegal <= 1'b0;
    end else if (!sel.legal) begin
      rd_data    <= '0;
      rd_illegal <= 1'b1;
    end else begin
      rd_illegal <= 1'b0;
      if (sel.hi) rd_data <= cnt_q[sel.slot][CTR_W-1:XLEN];
      else        rd_data <= cnt_q[sel.slot][XLEN-1:0];
    end
  end

  // R1: outputs are clear on the first cycle out of reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0) && !rd_illegal);

  // R9: an illegal read never carries data
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_illegal |-> (rd_data == '0));

  // R3: gated core clock freezes the cycle counter
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !core_run |=> $stable(cnt_q[SLOT_CYC]));

  // R4: the time counter moves only on a tick
  p_time_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rt_tick |=> $stable(cnt_q[SLOT_TIME]));

endmodule

// File: tb/perf_ctr_bank_bench.sv
module perf_ctr_bank_bench;

  localparam int XL  = 8;
  localparam int CW  = 2 * XL;
  localparam int NEV = 4;

  typedef struct {
    logic [XL-1:0] data;
    logic          ill;
    string         tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           core_run = 1'b0;
  logic           rt_tick = 1'b0;
  logic [1:0]     ret_cnt = '0;
  logic [NEV-1:0] evt_pulse = '0;
  logic [11:0]    rd_addr = '0;
  logic [XL-1:0]  rd_data;
  logic           rd_illegal;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0] m_cyc = '0, m_tim = '0, m_ret = '0;
  logic [CW-1:0] m_evt [NEV];
  exp_t q [$];

  always #2.5 clk = ~clk;

  perf_ctr_bank #(.XLEN(XL), .NUM_EVT(NEV)) u_perf_ctr_bank (
    .clk (clk), .rst (rst), .core_run (core_run), .rt_tick (rt_tick),
    .ret_cnt (ret_cnt), .evt_pulse (evt_pulse), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_illegal (rd_illegal)
  );

  function automatic logic [CW-1:0] slot_val(input logic [4:0] s);
    if (s == 0) return m_cyc;
    if (s == 1) return m_tim;
    if (s == 2) return m_ret;
    if (int'(s) < 3 + NEV) return m_evt[int'(s) - 3];
    return '0;
  endfunction

  function automatic exp_t expect_rd(input logic [11:0] a, input string tag);
    exp_t e;
    logic [CW-1:0] v;
    e.tag = tag; e.ill = 1'b0; e.data = '0;
    if (a[11:5] != 7'h60 && a[11:5] != 7'h64) begin
      e.ill = 1'b1;
      return e;
    end
    v = slot_val(a[4:0]);
    e.data = (a[11:5] == 7'h64) ? v[CW-1:XL] : v[XL-1:0];
    return e;
  endfunction

  task automatic step(input logic [11:0] a, input logic run, input logic tick,
                      input logic [1:0] rc, input logic [NEV-1:0] ev, input string tag);
    @(negedge clk);
    rd_addr = a; core_run = run; rt_tick = tick; ret_cnt = rc; evt_pulse = ev;
    q.push_back(expect_rd(a, tag));
    m_cyc = m_cyc + CW'(run);
    m_tim = m_tim + CW'(tick);
    m_ret = m_ret + ((rc == 2'd3) ? CW'(2) : CW'(rc));
    for (int j = 0; j < NEV; j++) m_evt[j] = m_evt[j] + CW'(ev[j]);
  endtask

  // monitor: compares each expected item against the registered output
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.data || rd_illegal !== it.ill) begin
        errors++;
        $display("FAIL %s addr=%h data=%h ill=%b expected data=%h ill=%b",
                 it.tag, rd_addr, rd_data, rd_illegal, it.data, it.ill);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < NEV; j++) m_evt[j] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rd_data !== '0 || rd_illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset data=%h ill=%b expected data=0 ill=0", rd_data, rd_illegal);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 / R7: sweep both windows with nothing counting
    for (int s = 0; s < 32; s++) begin
      step(12'hC00 + 12'(s), 1'b0, 1'b0, 2'd0, '0, (s >= 3 + NEV) ? "R7" : "R1");
      step(12'hC80 + 12'(s), 1'b0, 1'b0, 2'd0, '0, (s >= 3 + NEV) ? "R7" : "R2");
    end

    // R3: cycle counter runs, then holds while gated
    for (int i = 0; i < 20; i++) step(12'hC00, 1'b1, 1'b0, 2'd0, '0, "R3");
    for (int i = 0; i < 10; i++) step(12'hC00, 1'b0, 1'b0, 2'd0, '0, "R3");

    // R4: ticks every third cycle, independent of core_run
    for (int i = 0; i < 30; i++)
      step(12'hC01, 1'(i % 2), (i % 3) == 0, 2'd0, '0, "R4");

    // R5: retire counts 0,1,2,3 (3 treated as 2)
    for (int i = 0; i < 16; i++) step(12'hC02, 1'b1, 1'b0, 2'(i % 4), '0, "R5");

    // R6: event bit patterns, reading each event slot in turn
    for (int i = 0; i < 24; i++)
      step(12'hC03 + 12'(i % NEV), 1'b1, 1'b0, 2'd0, NEV'((i * 5) ^ (i >> 1)), "R6");

    // R9: addresses just outside each window and far away
    step(12'hBFF, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'hC20, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'hC7F, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'hCA0, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'h000, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'hFFF, 1'b1, 1'b0, 2'd0, '0, "R9");
    step(12'hC40, 1'b1, 1'b0, 2'd0, '0, "R9");

    // R10: idle repeated reads leave the counters frozen
    for (int i = 0; i < 12; i++)
      step((i % 2) ? 12'hC81 : 12'hC01, 1'b0, 1'b0, 2'd0, '0, "R10");
    for (int i = 0; i < 6; i++) step(12'hC02, 1'b0, 1'b0, 2'd0, '0, "R10");

    // R8: long run across the low-word boundary of the cycle counter
    for (int i = 0; i < 320; i++)
      step((i % 2) ? 12'hC00 : 12'hC80, 1'b1, 1'b1, 2'd0, '0, "R8");
    step(12'hC81, 1'b0, 1'b0, 2'd0, '0, "R8");

    step(12'hC00, 1'b0, 1'b0, 2'd0, '0, "R3");
    repeat (3) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule